// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small 8-bit processor built around two internal buses. A first bus carries one of the general registers or the program counter. A second bus carries the ALU result, the first bus, or the word read from a shared memory. The sequencer holds only its own state register and no datapath storage. From that state and the instruction register contents it produces every strobe the datapath needs: the general-register load enables, the address, instruction, operand and zero-flag register loads, the program-counter increment and load, the memory write strobe and the two bus source selects.

Each instruction is fetched in two cycles and decoded in one. Depending on the opcode it then spends zero, one or two cycles in execute states. One-byte instructions are the register-to-register operations. Two-byte instructions (memory read, memory write and branch) carry a memory address in their second byte, which the sequencer fetches through the address register. Opcodes outside the defined set lock the machine in a halt state until reset.

The reset input is asynchronous and active low, and it is expected to be deasserted in step with the clock by the chip reset tree. All outputs are decoded combinationally from the present state and the instruction word.

Top module: `seq_ctrl`

## Requirements
- R1: While rst_n is low, and in the single idle cycle after it rises, every strobe is 0. The next rising clock edge moves the machine to the first fetch cycle.
- R2: The first fetch cycle asserts ar_ld with bus1_sel = 4 (program counter) and bus2_sel = 1 (first bus). The second fetch cycle asserts ir_ld and pc_inc with bus2_sel = 2 (memory). The decode cycle follows.
- R3: The instruction word holds the opcode in bits 7:4, the source register in bits 3:2 and the destination register in bits 1:0. The opcodes are 0 no-op, 1 add, 2 subtract, 3 AND, 4 complement, 5 read, 6 write and 7 branch. General register n is driven on the first bus with bus1_sel = n and loaded by gpr_ld[n].
- R4: A no-op asserts no strobe in its decode cycle and is followed directly by the first fetch cycle.
- R5: A complement completes in its decode cycle. It asserts gpr_ld[dst] and zf_ld with bus1_sel = src and bus2_sel = 0 (ALU), and the first fetch cycle follows.
- R6: Add, subtract and AND assert y_ld in decode with bus1_sel = src and bus2_sel = 1. One execute cycle follows that asserts gpr_ld[dst] and zf_ld with bus1_sel = dst and bus2_sel = 0. The first fetch cycle comes next.
- R7: For read, write and branch, decode asserts ar_ld with bus1_sel = 4 and bus2_sel = 1. The first execute cycle then asserts ar_ld and pc_inc with bus2_sel = 2, which loads the second byte into the address register.
- R8: The second execute cycle of a read asserts gpr_ld[dst] with bus2_sel = 2, and the first fetch cycle follows.
- R9: The second execute cycle of a write asserts mem_we with bus1_sel = src and no register load, and the first fetch cycle follows.
- R10: A branch with bit 2 of the instruction clear is always taken. A branch with bit 2 set is taken only if zero_flag is 1 during its first execute cycle. A taken branch has a second execute cycle that asserts pc_ld with bus2_sel = 2. A branch not taken goes from its first execute cycle straight to the first fetch cycle.
- R11: Opcodes 8 to 15 produce no strobe in decode and then hold the machine with all strobes 0, whatever ir_word and zero_flag do, until rst_n is asserted.
- R12: At most one bit of gpr_ld is set in any cycle, and mem_we is never asserted together with a register or program-counter load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_word | input | 8 | Current instruction register contents |
| zero_flag | input | 1 | Zero flag from the datapath, used by the conditional branch |
| gpr_ld | output | 4 | Load enable for each general register |
| pc_ld | output | 1 | Load program counter from the second bus |
| pc_inc | output | 1 | Increment program counter |
| ir_ld | output | 1 | Load instruction register from the second bus |
| ar_ld | output | 1 | Load address register from the second bus |
| y_ld | output | 1 | Load ALU operand register from the second bus |
| zf_ld | output | 1 | Load zero flag from the ALU zero detect |
| mem_we | output | 1 | Memory write strobe, data taken from the first bus |
| bus1_sel | output | 3 | First bus source: 0 to 3 general register, 4 program counter |
| bus2_sel | output | 2 | Second bus source: 0 ALU, 1 first bus, 2 memory |

## Verification
The conditions hardest to reach from the ports are the branch that is not taken and the halt trap. The branch turns on zero_flag only in its first execute cycle, and the halt must ignore every later legal instruction word. The bench plays the part of the datapath. It presents each instruction word during fetch and changes zero_flag just before the first execute cycle of a conditional branch, so that taken and fall-through are each forced once. While halted it keeps cycling ir_word through legal opcodes and toggling zero_flag, and then checks that only a reset brings the fetch sequence back.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH_A,
    ST_FETCH_B,
    ST_DECODE,
    ST_EXEC_ALU,
    ST_EXEC_ADDR,
    ST_EXEC_RD,
    ST_EXEC_WR,
    ST_EXEC_BR,
    ST_HALT
  } seq_state_e;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd2;
  localparam logic [OPC_W-1:0] OPC_AND = 4'd3;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'd4;
  localparam logic [OPC_W-1:0] OPC_RD  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_WR  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_BR  = 4'd7;

  typedef enum logic [1:0] {
    B2_ALU  = 2'd0,
    B2_BUS1 = 2'd1,
    B2_MEM  = 2'd2
  } bus2_src_e;

endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import seq_ctrl_pkg::*;
(
  input  seq_state_e       state,
  input  logic [OPC_W-1:0] opcode,
  input  logic             br_cond,
  input  logic             zero_flag,
  output seq_state_e       state_nx
);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    state_nx = ST_FETCH_A;
      ST_FETCH_A: state_nx = ST_FETCH_B;
      ST_FETCH_B: state_nx = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_NOP, OPC_NOT:         state_nx = ST_FETCH_A;
          OPC_ADD, OPC_SUB, OPC_AND: state_nx = ST_EXEC_ALU;
          OPC_RD, OPC_WR, OPC_BR:   state_nx = ST_EXEC_ADDR;
          default:                  state_nx = ST_HALT;
        endcase
      end
      ST_EXEC_ADDR: begin
        case (opcode)
          OPC_RD:  state_nx = ST_EXEC_RD;
          OPC_WR:  state_nx = ST_EXEC_WR;
          OPC_BR:  state_nx = (br_cond && !zero_flag) ? ST_FETCH_A : ST_EXEC_BR;
          default: state_nx = ST_HALT;
        endcase
      end
      ST_EXEC_ALU, ST_EXEC_RD, ST_EXEC_WR, ST_EXEC_BR:
        state_nx = ST_FETCH_A;
      ST_HALT:  state_nx = ST_HALT;
      default:  state_nx = ST_HALT;
    endcase
  end

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import seq_ctrl_pkg::*;
#(
  parameter  int NREG   = 4,
  localparam int RSEL_W = $clog2(NREG),
  localparam int B1_W   = $clog2(NREG + 1)
) (
  input  seq_state_e        state,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RSEL_W-1:0] src,
  input  logic [RSEL_W-1:0] dst,
  output logic [NREG-1:0]   gpr_ld,
  output logic              pc_ld,
  output logic              pc_inc,
  output logic              ir_ld,
  output logic              ar_ld,
  output logic              y_ld,
  output logic              zf_ld,
  output logic              mem_we,
  output logic [B1_W-1:0]   bus1_sel,
  output bus2_src_e         bus2_sel
);

  localparam logic [B1_W-1:0] B1_PC = B1_W'(NREG);

  logic gpr_wr;

  always_comb begin
    gpr_wr   = 1'b0;
    pc_ld    = 1'b0;
    pc_inc   = 1'b0;
    ir_ld    = 1'b0;
    ar_ld    = 1'b0;
    y_ld     = 1'b0;
    zf_ld    = 1'b0;
    mem_we   = 1'b0;
    bus1_sel = '0;
    bus2_sel = B2_ALU;
    case (state)
      ST_FETCH_A: begin
        ar_ld    = 1'b1;
        bus1_sel = B1_PC;
        bus2_sel = B2_BUS1;
      end
      ST_FETCH_B: begin
        ir_ld    = 1'b1;
        pc_inc   = 1'b1;
        bus2_sel = B2_MEM;
      end
      ST_DECODE: begin
        case (opcode)
          OPC_NOT: begin
            gpr_wr   = 1'b1;
            zf_ld    = 1'b1;
            bus1_sel = B1_W'(src);
            bus2_sel = B2_ALU;
          end
          OPC_ADD, OPC_SUB, OPC_AND: begin
            y_ld     = 1'b1;
            bus1_sel = B1_W'(src);
            bus2_sel = B2_BUS1;
          end
          OPC_RD, OPC_WR, OPC_BR: begin
            ar_ld    = 1'b1;
            bus1_sel = B1_PC;
            bus2_sel = B2_BUS1;
          end
          default: ;
        endcase
      end
      ST_EXEC_ALU: begin
        gpr_wr   = 1'b1;
        zf_ld    = 1'b1;
        bus1_sel = B1_W'(dst);
        bus2_sel = B2_ALU;
      end
      ST_EXEC_ADDR: begin
        ar_ld    = 1'b1;
        pc_inc   = 1'b1;
        bus2_sel = B2_MEM;
      end
      ST_EXEC_RD: begin
        gpr_wr   = 1'b1;
        bus2_sel = B2_MEM;
      end
      ST_EXEC_WR: begin
        mem_we   = 1'b1;
        bus1_sel = B1_W'(src);
      end
      ST_EXEC_BR: begin
        pc_ld    = 1'b1;
        bus2_sel = B2_MEM;
      end
      default: ;
    endcase
  end

  // one load enable per general register, selected by the destination field
  for (genvar i = 0; i < NREG; i++) begin : g_gpr_ld
    assign gpr_ld[i] = gpr_wr && (dst == RSEL_W'(i));
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter  int NREG    = 4,
  localparam int RSEL_W  = $clog2(NREG),
  localparam int INSTR_W = OPC_W + 2 * RSEL_W,
  localparam int B1_W    = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ir_word,
  input  logic               zero_flag,
  output logic [NREG-1:0]    gpr_ld,
  output logic               pc_ld,
  output logic               pc_inc,
  output logic               ir_ld,
  output logic               ar_ld,
  output logic               y_ld,
  output logic               zf_ld,
  output logic               mem_we,
  output logic [B1_W-1:0]    bus1_sel,
  output logic [1:0]         bus2_sel
);

  seq_state_e        state_q;
  seq_state_e        state_nx;
  bus2_src_e         bus2_src;
  logic [OPC_W-1:0]  opcode;
  logic [RSEL_W-1:0] src;
  logic [RSEL_W-1:0] dst;

  // instruction fields: opcode on top, then source, then destination
  assign opcode = ir_word[INSTR_W-1 -: OPC_W];
  assign src    = ir_word[2*RSEL_W-1 -: RSEL_W];
  assign dst    = ir_word[RSEL_W-1:0];

  seq_next_state u_next (
    .state     (state_q),
    .opcode    (opcode),
    .br_cond   (src[0]),
    .zero_flag (zero_flag),
    .state_nx  (state_nx)
  );

  // rst_n is asserted asynchronously and deasserted in step with clk upstream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  seq_out_decode #(.NREG(NREG)) u_out (
    .state    (state_q),
    .opcode   (opcode),
    .src      (src),
    .dst      (dst),
    .gpr_ld   (gpr_ld),
    .pc_ld    (pc_ld),
    .pc_inc   (pc_inc),
    .ir_ld    (ir_ld),
    .ar_ld    (ar_ld),
    .y_ld     (y_ld),
    .zf_ld    (zf_ld),
    .mem_we   (mem_we),
    .bus1_sel (bus1_sel),
    .bus2_sel (bus2_src)
  );

  assign bus2_sel = bus2_src;

  // R1
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |=> state_q == ST_FETCH_A);

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |-> $past(ar_ld) && !$past(ir_ld));

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |=> state_q == ST_HALT && $stable(state_q));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_HALT |-> !(|gpr_ld) && !pc_ld && !pc_inc && !ir_ld
                           && !ar_ld && !y_ld && !zf_ld && !mem_we);

  // R12
  gpr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpr_ld));

  // R12
  write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> gpr_ld == '0 && !pc_ld);

  // R10
  pc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |-> bus2_sel == B2_MEM);

  // R7
  addr_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_ld && pc_inc) |=> state_q inside {ST_EXEC_RD, ST_EXEC_WR, ST_EXEC_BR, ST_FETCH_A});

endmodule

// File: tb/seq_ctrl_test.sv
module seq_ctrl_test;

  localparam int CLK_P = 10;

  // strobe vector layout: {gpr_ld[3:0], pc_ld, pc_inc, ir_ld, ar_ld, y_ld, zf_ld, mem_we}
  localparam logic [10:0] S_PCLD = 11'h040;
  localparam logic [10:0] S_INC  = 11'h020;
  localparam logic [10:0] S_IR   = 11'h010;
  localparam logic [10:0] S_AR   = 11'h008;
  localparam logic [10:0] S_Y    = 11'h004;
  localparam logic [10:0] S_ZF   = 11'h002;
  localparam logic [10:0] S_WE   = 11'h001;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ir_word;
  logic       zero_flag;
  logic [3:0] gpr_ld;
  logic       pc_ld, pc_inc, ir_ld, ar_ld, y_ld, zf_ld, mem_we;
  logic [2:0] bus1_sel;
  logic [1:0] bus2_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  seq_ctrl uut (
    .clk, .rst_n, .ir_word, .zero_flag,
    .gpr_ld, .pc_ld, .pc_inc, .ir_ld, .ar_ld, .y_ld, .zf_ld, .mem_we,
    .bus1_sel, .bus2_sel
  );

  function automatic logic [10:0] G(input int d);
    return 11'(1) << (7 + d);
  endfunction

  task automatic chk(input string req, input logic [10:0] es, input int eb1, input int eb2);
    logic [10:0] got;
    got = {gpr_ld, pc_ld, pc_inc, ir_ld, ar_ld, y_ld, zf_ld, mem_we};
    n_chk++;
    if (got !== es || (eb1 >= 0 && int'(bus1_sel) != eb1) ||
        (eb2 >= 0 && int'(bus2_sel) != eb2)) begin
      n_fail++;
      $display("FAIL %s: strobes=%b bus1=%0d bus2=%0d expected strobes=%b bus1=%0d bus2=%0d",
               req, got, bus1_sel, bus2_sel, es, eb1, eb2);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    ir_word = 8'h5A;
    #1 chk("R1 strobes in reset", '0, -1, -1);
    tick();
    chk("R1 strobes in reset, second cycle", '0, -1, -1);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 idle cycle after release", '0, -1, -1);
    tick();
    chk("R1 first fetch after release", S_AR, 4, 1);
  endtask

  task automatic fetch(input logic [7:0] instr);
    chk("R2 fetch cycle A", S_AR, 4, 1);
    ir_word = instr;
    tick();
    chk("R2 fetch cycle B", S_IR | S_INC, -1, 2);
    tick();
  endtask

  task automatic t_nop(input logic [7:0] instr);
    fetch(instr);
    chk("R4 no-op decode quiet", '0, -1, -1);
    tick();
    chk("R4 no-op returns to fetch", S_AR, 4, 1);
  endtask

  task automatic t_not(input int s, input int d);
    fetch({4'd4, 2'(s), 2'(d)});
    chk("R5 complement in decode", G(d) | S_ZF, s, 0);
    tick();
    chk("R5 complement returns to fetch", S_AR, 4, 1);
  endtask

  task automatic t_alu(input int op, input int s, input int d);
    fetch({4'(op), 2'(s), 2'(d)});
    chk("R3,R6 operand load in decode", S_Y, s, 1);
    tick();
    chk("R3,R6 result write in execute", G(d) | S_ZF, d, 0);
    tick();
    chk("R6 returns to fetch", S_AR, 4, 1);
  endtask

  // op: 5 read, 6 write, 7 branch; zf is driven during the first execute cycle
  task automatic t_mem(input int op, input int s, input int d, input logic zf, input bit taken);
    fetch({4'(op), 2'(s), 2'(d)});
    chk("R7 address from PC in decode", S_AR, 4, 1);
    zero_flag = ~zf;
    tick();
    zero_flag = zf;
    #1 chk("R7 second byte into address register", S_AR | S_INC, -1, 2);
    tick();
    zero_flag = ~zf;
    #1;
    if (op == 5) chk("R8 read loads destination", G(d), -1, 2);
    else if (op == 6) chk("R9,R12 write strobe from source", S_WE, s, -1);
    else if (taken) chk("R10 branch loads PC", S_PCLD, -1, 2);
    else begin
      chk("R10 branch not taken falls to fetch", S_AR, 4, 1);
      return;
    end
    tick();
    chk("R8,R9,R10 return to fetch", S_AR, 4, 1);
  endtask

  task automatic t_illegal(input logic [7:0] instr);
    fetch(instr);
    chk("R11 illegal decode quiet", '0, -1, -1);
    for (int i = 0; i < 12; i++) begin
      tick();
      ir_word   = 8'(8'h10 * (i % 8) + i);
      zero_flag = i[0];
      #1 chk("R11 halted stays quiet", '0, -1, -1);
    end
    do_reset();
    t_nop(8'h00);
  endtask

  initial begin
    rst_n     = 1'b0;
    ir_word   = 8'h00;
    zero_flag = 1'b0;
    do_reset();
    t_nop(8'h0B);
    t_not(2, 1);
    t_alu(1, 3, 0);
    t_alu(2, 0, 2);
    t_alu(3, 1, 1);
    t_mem(5, 0, 3, 1'b0, 1'b1);
    t_mem(6, 2, 0, 1'b1, 1'b1);
    t_mem(7, 0, 0, 1'b0, 1'b1);
    t_mem(7, 1, 2, 1'b0, 1'b0);
    t_mem(7, 1, 2, 1'b1, 1'b1);
    t_illegal(8'h8C);
    t_illegal(8'hF0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion within 5000 cycles");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule